// File: doc/BRIEF.md
# PRBS Loopback Self-Test Engine

This block runs the at-speed self-test of a 16-port serial switch datapath. While self-test is enabled, a seven-bit pseudo-random generator produces one bit per clock toward switch input port 0. The crossbar routes that stream to one chosen output. The loopback path returns the output to the input side, and the returned bit comes back into the block. A checker inside the block first synchronises to the returning stream and then compares it bit by bit. While the stream stays error-free, a pass flag is held high.

Only port 0 ever carries the injected pattern. Port N is tested by configuring the crossbar so that port 0 is routed through port N and back. A full sweep therefore needs one crossbar configuration per port, which is sixteen runs. The loop latency depends on the route, so the checker ignores a fixed number of bits before it locks. It then loads its reference state from the stream itself, which makes the result independent of the exact delay.

Top module: `bist_prbs_engine`

## Requirements
- R1: While `bist_en` is low, `src_bit` is 0 and the generator is held at its all-ones seed.
- R2: While `bist_en` is high, `src_bit` follows b[n] = b[n-6] XOR b[n-7], with bit 0 given by `src_bit` in the first cycle of enable and with b[-7..-1] all ones (so b[0] = 0). The stream repeats every 127 bits.
- R3: `lpbk_on` is high exactly when `bist_en` is high, `lpbk_req` is high and `test_mode` is low.
- R4: `pass` is low whenever `lpbk_on` is low.
- R5: Counting clock edges from the first edge with `lpbk_on` high, edges 1 to SETTLE discard the returned bit. Edges SETTLE+1 to SETTLE+7 load the reference. `pass` is low up to and including edge SETTLE+6, and it goes high after edge SETTLE+7 if nothing has failed.
- R6: After lock, each returned bit is compared with the reference, which runs on its own. Every port whose loop delay is at most SETTLE cycles keeps `pass` high for as long as the loop is intact.
- R7: A single wrong returned bit after lock drops `pass` after the edge that samples it. `pass` then stays low while `bist_en` stays high.
- R8: Taking `bist_en` low and then high again clears a recorded failure. The checker relocks and `pass` rises again per R5.
- R9: A reference loaded as all zeros (for example from a dead loop) counts as a failure, so `pass` never rises.
- R10: Dropping `lpbk_on` while `bist_en` stays high restarts the settle and load phases but keeps any recorded failure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bist_en | input | 1 | Self-test enable |
| lpbk_req | input | 1 | Request to loop all outputs back to their inputs |
| test_mode | input | 1 | Test-mode override; when high it blocks the loopback |
| src_bit | output | 1 | Pseudo-random bit toward switch input port 0 |
| ret_bit | input | 1 | Bit returned through the crossbar and the loopback |
| lpbk_on | output | 1 | Loopback actually engaged |
| pass | output | 1 | Checker locked with no mismatch seen |

## Verification
The assertions take for granted that the returned stream is a delayed copy of `src_bit`, with a fixed delay of at most SETTLE cycles, and that the control inputs change only between clock edges. The bench builds the loop from a delay line whose tap is chosen per port, with delays from 1 to 8 cycles. It switches the loop off by forcing the return to zero, and it corrupts the stream only by flipping a single bit in the return path or by holding the return at zero. Control changes are driven on the falling edge, so every edge sees stable inputs.

// File: rtl/bist_prbs_pkg.sv
package bist_prbs_pkg;
  localparam int PRBS_W = 7;
  typedef logic [PRBS_W-1:0] prbs_t;
  localparam prbs_t PRBS_SEED = '1;

  // feedback of x^7 + x^6 + 1: oldest bit xor second oldest
  function automatic logic prbs_fb(input prbs_t s);
    return s[PRBS_W-1] ^ s[PRBS_W-2];
  endfunction

  function automatic prbs_t prbs_shift(input prbs_t s, input logic b);
    return {s[PRBS_W-2:0], b};
  endfunction
endpackage

// File: rtl/bist_prbs_gen.sv
module bist_prbs_gen
  import bist_prbs_pkg::*;
#(
  parameter prbs_t SEED = PRBS_SEED
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bit_o
);
  prbs_t state_q;
  logic  fb_w;

  assign fb_w  = prbs_fb(state_q);
  assign bit_o = run & fb_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state_q <= SEED;
    else if (!run) state_q <= SEED;
    else          state_q <= prbs_shift(state_q, fb_w);
  end

  // R2
  prbs_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> state_q != '0);
  // R1
  seed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> state_q == SEED);
endmodule

// File: rtl/bist_prbs_chk.sv
module bist_prbs_chk
  import bist_prbs_pkg::*;
#(
  parameter int SETTLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic loop_on,
  input  logic rx,
  output logic locked,
  output logic err,
  output logic mm_evt,
  output logic zero_evt
);
  localparam int LOCK_AT = SETTLE + PRBS_W;
  localparam int CNT_W   = $clog2(LOCK_AT + 1);
  localparam logic [CNT_W-1:0] SETTLE_C = CNT_W'(SETTLE);
  localparam logic [CNT_W-1:0] LOCK_C   = CNT_W'(LOCK_AT);

  logic [CNT_W-1:0] cnt_q;
  prbs_t            ref_q;
  logic             err_q;
  logic             loading_w, load_last_w, exp_w;

  assign locked      = (cnt_q == LOCK_C);
  assign loading_w   = loop_on && (cnt_q >= SETTLE_C) && !locked;
  assign load_last_w = loading_w && (cnt_q == LOCK_C - 1'b1);
  assign exp_w       = prbs_fb(ref_q);
  assign mm_evt      = loop_on && locked && (rx != exp_w);
  assign zero_evt    = load_last_w && (prbs_shift(ref_q, rx) == '0);
  assign err         = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ref_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (!loop_on)     cnt_q <= '0;
      else if (!locked) cnt_q <= cnt_q + 1'b1;

      if (loading_w)             ref_q <= prbs_shift(ref_q, rx);
      else if (locked && loop_on) ref_q <= prbs_shift(ref_q, exp_w);

      if (!en)                       err_q <= 1'b0;
      else if (mm_evt || zero_evt)   err_q <= 1'b1;
    end
  end

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && err_q |=> err_q);
  // R5
  lock_needs_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(loop_on));
  // R10
  relock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_on |=> !locked);
endmodule

// File: rtl/bist_prbs_engine.sv
module bist_prbs_engine
  import bist_prbs_pkg::*;
#(
  parameter int    SETTLE = 8,
  parameter prbs_t SEED   = PRBS_SEED
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bist_en,
  input  logic lpbk_req,
  input  logic test_mode,
  output logic src_bit,
  input  logic ret_bit,
  output logic lpbk_on,
  output logic pass
);
  logic locked_w, err_w, mm_evt_w, zero_evt_w;

  assign lpbk_on = bist_en & lpbk_req & ~test_mode;

  bist_prbs_gen #(.SEED(SEED)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (bist_en),
    .bit_o (src_bit)
  );

  bist_prbs_chk #(.SETTLE(SETTLE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (bist_en),
    .loop_on  (lpbk_on),
    .rx       (ret_bit),
    .locked   (locked_w),
    .err      (err_w),
    .mm_evt   (mm_evt_w),
    .zero_evt (zero_evt_w)
  );

  assign pass = lpbk_on & locked_w & ~err_w;

  // R7
  mm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mm_evt_w && bist_en |=> !pass);
  // R9
  zero_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt_w && bist_en |=> !pass);
  // R8
  enable_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bist_en) |-> !pass);
  // R4
  override_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode |-> !pass);
endmodule

// File: tb/test_bist_prbs_engine.sv
module test_bist_prbs_engine;
  localparam int SETTLE = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bist_en = 1'b0, lpbk_req = 1'b0, test_mode = 1'b0;
  logic src_bit, ret_bit, lpbk_on, pass;
  logic [7:0] dl = '0;
  int   dly = 1;
  logic inj = 1'b0, force0 = 1'b0;
  int   errors = 0, checks = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) dl <= {dl[6:0], src_bit};
  assign ret_bit = (lpbk_on && !force0) ? (dl[dly-1] ^ inj) : 1'b0;

  bist_prbs_engine #(.SETTLE(SETTLE)) i_bist_prbs_engine (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .lpbk_req(lpbk_req),
    .test_mode(test_mode), .src_bit(src_bit), .ret_bit(ret_bit),
    .lpbk_on(lpbk_on), .pass(pass)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // expected stream from the recurrence, history of ones before bit 0
  function automatic logic ref_bit(input int n);
    logic h[0:199];
    for (int i = 0; i <= n + 7; i++) begin
      if (i < 7) h[i] = 1'b1;
      else       h[i] = h[i-6] ^ h[i-7];
    end
    return h[n + 7];
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_port(input int p);
    int bad_src, low_cnt;
    dly = 1 + (p % 8);
    bad_src = 0;
    low_cnt = 0;
    bist_en = 1'b1; lpbk_req = 1'b1; test_mode = 1'b0;
    #1;
    if (p == 0 && src_bit !== ref_bit(0)) bad_src++;
    for (int k = 1; k <= 140; k++) begin
      @(negedge clk);
      if (p == 0 && src_bit !== ref_bit(k)) bad_src++;
      if (k == SETTLE + 6) chk(pass == 1'b0, $sformatf("R5 port%0d pre-lock", p), pass, 0);
      if (k == SETTLE + 7) chk(pass == 1'b1, $sformatf("R5 port%0d lock", p), pass, 1);
      if (k > SETTLE + 7 && !pass) low_cnt++;
    end
    if (p == 0) begin
      chk(bad_src == 0, "R2 stream", bad_src, 0);
      chk(ref_bit(127) == ref_bit(0) && ref_bit(130) == ref_bit(3), "R2 period", ref_bit(130), ref_bit(3));
    end
    chk(low_cnt == 0, $sformatf("R6 port%0d steady pass", p), low_cnt, 0);
    // single bit error in the loop
    inj = 1'b1;
    @(negedge clk);
    inj = 1'b0;
    #1;
    chk(pass == 1'b0, $sformatf("R7 port%0d drop", p), pass, 0);
    cycles(20);
    chk(pass == 1'b0, $sformatf("R7 port%0d sticky", p), pass, 0);
    // loopback off and on keeps the failure
    test_mode = 1'b1;
    @(negedge clk);
    test_mode = 1'b0;
    cycles(SETTLE + 20);
    chk(pass == 1'b0, $sformatf("R10 port%0d err kept", p), pass, 0);
    // disable and re-enable clears it
    bist_en = 1'b0;
    #1;
    chk(pass == 1'b0, $sformatf("R4 port%0d disabled", p), pass, 0);
    @(negedge clk);
    bist_en = 1'b1;
    cycles(SETTLE + 7);
    chk(pass == 1'b1, $sformatf("R8 port%0d relock", p), pass, 1);
    bist_en = 1'b0;
    cycles(3);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    chk(src_bit == 1'b0, "R1 src idle", src_bit, 0);
    chk(pass == 1'b0, "R4 reset pass", pass, 0);
    chk(lpbk_on == 1'b0, "R3 reset lpbk", lpbk_on, 0);
    lpbk_req = 1'b1;
    cycles(5);
    chk(src_bit == 1'b0, "R1 src idle with req", src_bit, 0);

    for (int p = 0; p < 16; p++) run_port(p);

    // R9 dead loop returns zeros
    force0 = 1'b1;
    bist_en = 1'b1; lpbk_req = 1'b1; test_mode = 1'b0;
    cycles(SETTLE + 30);
    chk(pass == 1'b0, "R9 zero lock", pass, 0);
    bist_en = 1'b0;
    force0 = 1'b0;
    cycles(3);

    // R10 without error: toggle loop off, relock timing restarts
    bist_en = 1'b1; dly = 3;
    cycles(SETTLE + 10);
    chk(pass == 1'b1, "R10 locked before toggle", pass, 1);
    lpbk_req = 1'b0;
    @(negedge clk);
    lpbk_req = 1'b1;
    cycles(SETTLE + 6);
    chk(pass == 1'b0, "R10 relock pending", pass, 0);
    @(negedge clk);
    chk(pass == 1'b1, "R10 relocked", pass, 1);

    // R3 and R4 control sweep
    for (int c = 0; c < 8; c++) begin
      bist_en = c[2]; lpbk_req = c[1]; test_mode = c[0];
      #1;
      chk(lpbk_on == (c[2] & c[1] & ~c[0]), $sformatf("R3 combo%0d", c), lpbk_on, c[2] & c[1] & ~c[0]);
      if (!(c[2] & c[1] & ~c[0]))
        chk(pass == 1'b0, $sformatf("R4 combo%0d", c), pass, 0);
      @(negedge clk);
    end
    bist_en = 1'b0;
    cycles(2);
    chk(src_bit == 1'b0, "R1 src after disable", src_bit, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule